// File: doc/BRIEF.md
# Triple-Redundant Logic Voter with Fixed-Priority Fallback

This block merges a bank of single-bit logic signals produced by three redundant control channels, called R, S and T. Each channel delivers a signal vector and a health flag. While all three channels are healthy, every output bit is the two-out-of-three majority of the three copies. Once any channel is lost, voting is abandoned and one designated channel alone drives the outputs.

The designated channel comes from a fixed priority: R first, then S. T is never designated. If neither R nor S is healthy, the outputs freeze at their last registered values and a fault flag is raised. The block also reports the designated channel, raises a per-bit disagreement flag during full voting, and keeps a sticky, saturating count of the frames in which any disagreement was seen.

All evaluation happens on a frame vote strobe. Health changes between strobes therefore take effect only at the next strobe, so the designation never changes partway through a frame.

Top module: `tmr_vote_unit`

## Requirements
- R1: On a strobe with all three channels healthy, each `voted` bit becomes the majority of the matching `r_bits`, `s_bits` and `t_bits` bits.
- R2: On a strobe with all three channels healthy, `desig` becomes 2'b01, which marks R as designated.
- R3: On a strobe with R unhealthy and S healthy, `voted` becomes `s_bits` and `desig` becomes 2'b10. This holds whatever the health of T is.
- R4: `desig` never takes the value 2'b11, so T is never designated under any health combination.
- R5: On a strobe with R healthy and S or T unhealthy, `voted` becomes `r_bits` unchanged (no voting) and `desig` becomes 2'b01.
- R6: On a strobe with neither R nor S healthy, `voted` keeps its previous value, `fault` becomes 1 and `desig` becomes 2'b00. Any later strobe with R or S healthy clears `fault`.
- R7: On a strobe with all three channels healthy, bit i of `bit_disagree` becomes 1 exactly when the three copies of bit i are not all equal. On any other strobe, `bit_disagree` becomes all zeros.
- R8: `mismatch_count` increases by one on each strobe that has all three channels healthy and at least one disagreeing bit. It stops at its all-ones value and never decreases except through reset.
- R9: Outputs change only on the clock edge at which `vote_stb` is high, and they are visible one clock after that strobe. Data and health inputs seen without a strobe have no effect.
- R10: While `rst_n` is low, `voted`, `bit_disagree`, `desig`, `fault` and `mismatch_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vote_stb | input | 1 | Frame vote strobe; evaluation happens only in this cycle |
| r_bits | input | NBITS | Signal vector from channel R |
| s_bits | input | NBITS | Signal vector from channel S |
| t_bits | input | NBITS | Signal vector from channel T |
| r_ok | input | 1 | Channel R healthy |
| s_ok | input | 1 | Channel S healthy |
| t_ok | input | 1 | Channel T healthy |
| voted | output | NBITS | Registered resolved logic outputs |
| bit_disagree | output | NBITS | Per-bit disagreement from the last full-vote strobe |
| desig | output | 2 | Designated channel: 00 none, 01 R, 10 S |
| fault | output | 1 | Neither R nor S was healthy at the last strobe |
| mismatch_count | output | CNT_W | Sticky saturating count of disagreeing frames |

## Verification
A wrong mode decision shows up at the ports one clock after the strobe that caused it. It appears as a `desig` code that does not match the health pattern, or as `voted` following the wrong channel. The bench therefore uses channel vectors that differ from each other, so that each source can be told apart. A register that updates without a strobe shows up in the first non-strobe cycle in which the inputs change, so inputs are scrambled between strobes. A counter that misses an increment or wraps is seen as soon as it is compared after each disagreeing frame, including past saturation with a narrow counter.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

  typedef enum logic [1:0] {
    MODE_TRIPLE   = 2'd0,
    MODE_FOLLOW_R = 2'd1,
    MODE_FOLLOW_S = 2'd2,
    MODE_HOLD     = 2'd3
  } vote_mode_e;

  localparam logic [1:0] DSG_NONE = 2'b00;
  localparam logic [1:0] DSG_R    = 2'b01;
  localparam logic [1:0] DSG_S    = 2'b10;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic not_unanimous(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

  function automatic logic [1:0] dsg_of_mode(input vote_mode_e m);
    case (m)
      MODE_TRIPLE, MODE_FOLLOW_R: return DSG_R;
      MODE_FOLLOW_S:              return DSG_S;
      default:                    return DSG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tmr_mode_sel.sv
module tmr_mode_sel
  import tmr_vote_pkg::*;
(
  input  logic       r_ok,
  input  logic       s_ok,
  input  logic       t_ok,
  output vote_mode_e mode,
  output logic [1:0] dsg_code
);

  always_comb begin
    if (r_ok && s_ok && t_ok) mode = MODE_TRIPLE;
    else if (r_ok)            mode = MODE_FOLLOW_R;
    else if (s_ok)            mode = MODE_FOLLOW_S;
    else                      mode = MODE_HOLD;
  end

  assign dsg_code = dsg_of_mode(mode);

endmodule

// File: rtl/tmr_bit_voter.sv
module tmr_bit_voter
  import tmr_vote_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic [NBITS-1:0] a_bits,
  input  logic [NBITS-1:0] b_bits,
  input  logic [NBITS-1:0] c_bits,
  output logic [NBITS-1:0] maj_bits,
  output logic [NBITS-1:0] split_bits
);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign maj_bits[i]   = maj3(a_bits[i], b_bits[i], c_bits[i]);
    assign split_bits[i] = not_unanimous(a_bits[i], b_bits[i], c_bits[i]);
  end

endmodule

// File: rtl/tmr_sat_counter.sv
module tmr_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic at_top;
  assign at_top = (count == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (bump && !at_top) count <= count + 1'b1;
  end

  // R8: one step per counted frame
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !at_top) |=> (count == $past(count) + 1'b1));

  // R8: sticky, only bumps change it
  assert_count_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump || at_top) |=> $stable(count));

endmodule

// File: rtl/tmr_vote_unit.sv
module tmr_vote_unit
  import tmr_vote_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vote_stb,
  input  logic [NBITS-1:0] r_bits,
  input  logic [NBITS-1:0] s_bits,
  input  logic [NBITS-1:0] t_bits,
  input  logic             r_ok,
  input  logic             s_ok,
  input  logic             t_ok,
  output logic [NBITS-1:0] voted,
  output logic [NBITS-1:0] bit_disagree,
  output logic [1:0]       desig,
  output logic             fault,
  output logic [CNT_W-1:0] mismatch_count
);

  vote_mode_e       mode;
  logic [1:0]       dsg_code;
  logic [NBITS-1:0] maj_bits;
  logic [NBITS-1:0] split_bits;

  // named internal events
  logic frame_split;
  logic count_bump;
  logic evt_hold;

  tmr_mode_sel u_mode (
    .r_ok     (r_ok),
    .s_ok     (s_ok),
    .t_ok     (t_ok),
    .mode     (mode),
    .dsg_code (dsg_code)
  );

  tmr_bit_voter #(.NBITS(NBITS)) u_vote (
    .a_bits     (r_bits),
    .b_bits     (s_bits),
    .c_bits     (t_bits),
    .maj_bits   (maj_bits),
    .split_bits (split_bits)
  );

  assign frame_split = |split_bits;
  assign count_bump  = vote_stb && (mode == MODE_TRIPLE) && frame_split;
  assign evt_hold    = vote_stb && (mode == MODE_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      voted        <= '0;
      bit_disagree <= '0;
      desig        <= DSG_NONE;
      fault        <= 1'b0;
    end else if (vote_stb) begin
      desig <= dsg_code;
      fault <= (mode == MODE_HOLD);
      case (mode)
        MODE_TRIPLE: begin
          voted        <= maj_bits;
          bit_disagree <= split_bits;
        end
        MODE_FOLLOW_R: begin
          voted        <= r_bits;
          bit_disagree <= '0;
        end
        MODE_FOLLOW_S: begin
          voted        <= s_bits;
          bit_disagree <= '0;
        end
        default: begin
          bit_disagree <= '0;
        end
      endcase
    end
  end

  tmr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (count_bump),
    .count (mismatch_count)
  );

  // R4: T never designated
  assert_no_t_desig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desig != 2'b11);

  // R3: S takes over when R is lost
  assert_follow_s_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_stb && !r_ok && s_ok) |=> (voted == $past(s_bits) && desig == DSG_S));

  // R5: R drives directly on partial loss
  assert_follow_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_stb && r_ok && !(s_ok && t_ok)) |=> (voted == $past(r_bits) && desig == DSG_R));

  // R6: hold and flag fault
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hold |=> ($stable(voted) && fault && desig == DSG_NONE));

  // R9: nothing moves without a strobe
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_stb |=> ($stable(voted) && $stable(desig) && $stable(fault) && $stable(bit_disagree)));

  // R7: disagreement only reported in full voting
  assert_split_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_stb && !(r_ok && s_ok && t_ok)) |=> (bit_disagree == '0));

endmodule

// File: tb/test_tmr_vote_unit.sv
`timescale 1ns/1ps
module test_tmr_vote_unit;

  localparam int NB = 8;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vote_stb = 1'b0;
  logic [NB-1:0] r_bits = '0, s_bits = '0, t_bits = '0;
  logic r_ok = 1'b0, s_ok = 1'b0, t_ok = 1'b0;
  logic [NB-1:0] voted, bit_disagree;
  logic [1:0] desig;
  logic fault;
  logic [CW-1:0] mismatch_count;

  always #4 clk = ~clk;

  tmr_vote_unit #(.NBITS(NB), .CNT_W(CW)) i_tmr_vote_unit (
    .clk(clk), .rst_n(rst_n), .vote_stb(vote_stb),
    .r_bits(r_bits), .s_bits(s_bits), .t_bits(t_bits),
    .r_ok(r_ok), .s_ok(s_ok), .t_ok(t_ok),
    .voted(voted), .bit_disagree(bit_disagree), .desig(desig),
    .fault(fault), .mismatch_count(mismatch_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [NB-1:0] m_voted = '0, m_dis = '0;
  int m_dsg = 0, m_fault = 0, m_cnt = 0;
  string tag_v = "R10", tag_d = "R10";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_voted = '0; m_dis = '0; m_dsg = 0; m_fault = 0; m_cnt = 0;
      tag_v = "R10"; tag_d = "R10";
    end else if (vote_stb) begin
      if (r_ok && s_ok && t_ok) begin
        for (int i = 0; i < NB; i++) begin
          int ones;
          ones = int'(r_bits[i]) + int'(s_bits[i]) + int'(t_bits[i]);
          m_voted[i] = (ones >= 2);
          m_dis[i] = (ones == 1 || ones == 2);
        end
        if (m_dis != 0 && m_cnt < CMAX) m_cnt++;
        m_dsg = 1; m_fault = 0; tag_v = "R1"; tag_d = "R2";
      end else if (r_ok) begin
        m_voted = r_bits; m_dis = '0; m_dsg = 1; m_fault = 0; tag_v = "R5"; tag_d = "R5";
      end else if (s_ok) begin
        m_voted = s_bits; m_dis = '0; m_dsg = 2; m_fault = 0; tag_v = "R3"; tag_d = "R3";
      end else begin
        m_dis = '0; m_dsg = 0; m_fault = 1; tag_v = "R6"; tag_d = "R6";
      end
    end else begin
      tag_v = "R9"; tag_d = "R9";
    end
  endtask

  task automatic compare_all();
    chk(tag_v, "voted", int'(voted), int'(m_voted));
    chk(tag_d, "desig", int'(desig), m_dsg);
    chk("R6", "fault", int'(fault), m_fault);
    chk("R7", "bit_disagree", int'(bit_disagree), int'(m_dis));
    chk("R8", "mismatch_count", int'(mismatch_count), m_cnt);
    chk("R4", "desig_not_T", int'(desig == 2'b11), 0);
  endtask

  task automatic step(input bit stb, input logic [NB-1:0] r, input logic [NB-1:0] s,
                      input logic [NB-1:0] t, input bit ro, input bit so, input bit to);
    @(negedge clk);
    vote_stb = stb; r_bits = r; s_bits = s; t_bits = t; r_ok = ro; s_ok = so; t_ok = to;
    @(posedge clk);
    model_edge();
    #2;
    compare_all();
  endtask

  initial begin
    // R10: reset state
    step(1, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1);
    step(0, 8'h5A, 8'hA5, 8'h3C, 1, 1, 1);
    rst_n = 1'b1;

    // R1 R2 R7 R8: full voting, distinct patterns
    step(1, 8'hF0, 8'hCC, 8'hAA, 1, 1, 1);
    step(1, 8'h3C, 8'h3C, 8'h3C, 1, 1, 1);
    step(1, 8'h0F, 8'hF0, 8'h00, 1, 1, 1);
    // R9: inputs change without strobe
    step(0, 8'h11, 8'h22, 8'h44, 0, 0, 0);
    step(0, 8'hEE, 8'hDD, 8'hBB, 1, 0, 1);
    // R5: T lost, then S lost
    step(1, 8'h96, 8'h00, 8'hFF, 1, 1, 0);
    step(1, 8'h69, 8'hFF, 8'h00, 1, 0, 1);
    // R3: R lost, T healthy and T lost
    step(1, 8'h00, 8'hC3, 8'h3C, 0, 1, 1);
    step(1, 8'hFF, 8'h5A, 8'hA5, 0, 1, 0);
    // R6: hold, with T alone healthy and with nothing healthy
    step(1, 8'h12, 8'h34, 8'h56, 0, 0, 1);
    step(1, 8'h78, 8'h9A, 8'hBC, 0, 0, 0);
    step(0, 8'h00, 8'h00, 8'h00, 1, 1, 1);
    // recovery clears fault
    step(1, 8'h81, 8'h81, 8'h7E, 1, 1, 1);
    // R8: drive counter into saturation
    for (int k = 0; k < 12; k++)
      step(1, 8'h01 << (k % 8), 8'h00, 8'h00, 1, 1, 1);
    // R7: disagreement-free frame clears flags
    step(1, 8'h55, 8'h55, 8'h55, 1, 1, 1);
    // mixed sweep over all health combinations
    for (int k = 0; k < 300; k++) begin
      logic [NB-1:0] a, b, c;
      a = NB'($urandom); b = NB'($urandom); c = NB'($urandom);
      step((k % 3) != 0, a, b, c, k[0], k[1], k[2]);
    end
    // reset mid-run returns to zero
    rst_n = 1'b0;
    step(1, 8'hAA, 8'h55, 8'hFF, 1, 1, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule